// File: doc/BRIEF.md
# Routing-by-Agreement Sequence Controller

This block is the finite-state sequencer that steps a shared multiply-accumulate array through the iterative routing between the last two capsule layers. For each phase it sets where the array takes its predictions from (the data buffer or the horizontal feedback path) and where it takes its coefficients from (the uniform initial constant or the routing buffer). It also selects the activation function, gates the routing-buffer writes and says which buffer region receives them. It counts routing iterations and raises a one-cycle done flag at the end.

A run begins on a start pulse and takes an iteration count sampled at that moment. The first phase skips the usual softmax over all-zero logits. It feeds the uniform coupling constant straight into the array, forms the weighted sums and squashes them. Each later iteration runs an update-and-softmax phase and then a sum-and-squash phase. In both of these phases the predictions come back over the feedback path, so the data buffer is not read again. Each phase lasts until the datapath reports completion, however long that takes.

Top module: `routing_seq_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done and phase_go are 0, act_sel is 00 (none), data_sel, coef_sel, rbuf_region and rbuf_we are 0, and iter_idx is 0.
- R2: A start pulse while idle captures num_iters and moves to the first phase in the next cycle. In that cycle busy goes to 1, phase_go is 1 for exactly one cycle and iter_idx is 1.
- R3: The first phase drives data_sel=0 (data buffer), coef_sel=1 (uniform constant), act_sel=01 (squash) and rbuf_region=0 (squash-output region).
- R4: The update phase drives data_sel=1 (feedback), coef_sel=0 (routing buffer), act_sel=10 (softmax) and rbuf_region=1 (coefficient region).
- R5: The later sum phase drives data_sel=1, coef_sel=0, act_sel=01 and rbuf_region=0.
- R6: For a count N the phase order is the first phase, then the pair (update, later sum) N-1 times. iter_idx increments on each entry into the update phase.
- R7: A phase holds its outputs for as many cycles as dp_done stays low. A dp_done sampled high moves to the next phase in the following cycle, and phase_go is high in that cycle.
- R8: In the cycle after the final dp_done, done is 1 for one cycle, busy is 0 and iter_idx returns to 0.
- R9: A count of 0 behaves as 1. A count of 1 runs the first phase only.
- R10: A start pulse while busy and a dp_done pulse while idle have no effect on any output.
- R11: rbuf_we is 1 exactly when busy and dp_valid are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a routing run (used only when idle) |
| num_iters | input | IW | Routing iteration count, captured at start |
| dp_valid | input | 1 | Datapath result beat valid |
| dp_done | input | 1 | Datapath completed the current phase |
| phase_go | output | 1 | One-cycle pulse at entry to each phase |
| data_sel | output | 1 | Prediction source: 0 data buffer, 1 feedback |
| coef_sel | output | 1 | Coefficient source: 0 routing buffer, 1 uniform constant |
| act_sel | output | 2 | Activation: 00 none, 01 squash, 10 softmax |
| rbuf_we | output | 1 | Routing buffer write enable |
| rbuf_region | output | 1 | Write region: 0 squash outputs, 1 coefficients |
| busy | output | 1 | A routing run is in progress |
| iter_idx | output | IW | Current routing iteration, 0 when idle |
| done | output | 1 | One-cycle pulse when a run finishes |

## Verification
The assertions assume that dp_done arrives only after the datapath has seen the phase_go of the current phase. A softmax completion must therefore always land the controller in a squash phase. The stub in the bench honours this: it waits for phase_go and then stalls for a chosen number of cycles, sometimes zero. Only after the stall does it pulse dp_done, with dp_valid toggled during the stall. Stray start pulses during a run and stray dp_done pulses while idle are injected on purpose, because the controller must ignore them.

// File: rtl/routing_seq_pkg.sv
package routing_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_UPD   = 2'd2,
        ST_SUM   = 2'd3
    } seq_state_t;

    localparam logic [1:0] ACT_NONE    = 2'b00;
    localparam logic [1:0] ACT_SQUASH  = 2'b01;
    localparam logic [1:0] ACT_SOFTMAX = 2'b10;

    typedef struct packed {
        seq_state_t state;
        logic       go;
        logic       fin;
    } seq_regs_t;

endpackage

// File: rtl/routing_iter_cnt.sv
module routing_iter_cnt #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] lim_in,
    input  logic          inc,
    input  logic          clear,
    output logic [IW-1:0] iter_o,
    output logic          last_o
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] iter_d, iter_q;
    logic [IW-1:0] lim_d, lim_q;

    always_comb begin
        iter_d = iter_q;
        lim_d  = lim_q;
        if (load) begin
            iter_d = ONE;
            lim_d  = (lim_in == '0) ? ONE : lim_in;
        end else if (clear) begin
            iter_d = '0;
        end else if (inc) begin
            iter_d = iter_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iter_q <= '0;
            lim_q  <= ONE;
        end else begin
            iter_q <= iter_d;
            lim_q  <= lim_d;
        end
    end

    assign iter_o = iter_q;
    assign last_o = (iter_q >= lim_q);
endmodule

// File: rtl/routing_phase_decode.sv
module routing_phase_decode
    import routing_seq_pkg::*;
(
    input  seq_state_t state,
    input  logic       dp_valid,
    output logic       data_sel,
    output logic       coef_sel,
    output logic [1:0] act_sel,
    output logic       rbuf_region,
    output logic       rbuf_we,
    output logic       busy
);
    always_comb begin
        data_sel    = 1'b0;
        coef_sel    = 1'b0;
        act_sel     = ACT_NONE;
        rbuf_region = 1'b0;
        busy        = 1'b1;
        unique case (state)
            ST_FIRST: begin
                coef_sel = 1'b1;
                act_sel  = ACT_SQUASH;
            end
            ST_UPD: begin
                data_sel    = 1'b1;
                act_sel     = ACT_SOFTMAX;
                rbuf_region = 1'b1;
            end
            ST_SUM: begin
                data_sel = 1'b1;
                act_sel  = ACT_SQUASH;
            end
            default: busy = 1'b0;
        endcase
        rbuf_we = busy & dp_valid;
    end
endmodule

// File: rtl/routing_seq_ctrl.sv
module routing_seq_ctrl
    import routing_seq_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] num_iters,
    input  logic          dp_valid,
    input  logic          dp_done,
    output logic          phase_go,
    output logic          data_sel,
    output logic          coef_sel,
    output logic [1:0]    act_sel,
    output logic          rbuf_we,
    output logic          rbuf_region,
    output logic          busy,
    output logic [IW-1:0] iter_idx,
    output logic          done
);
    seq_regs_t r_d, r_q;
    logic      cnt_load, cnt_inc, cnt_clear, cnt_last;

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.fin   = 1'b0;
        cnt_load  = 1'b0;
        cnt_inc   = 1'b0;
        cnt_clear = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_FIRST;
                    r_d.go    = 1'b1;
                    cnt_load  = 1'b1;
                end
            end
            ST_FIRST, ST_SUM: begin
                if (dp_done) begin
                    if (cnt_last) begin
                        r_d.state = ST_IDLE;
                        r_d.fin   = 1'b1;
                        cnt_clear = 1'b1;
                    end else begin
                        r_d.state = ST_UPD;
                        r_d.go    = 1'b1;
                        cnt_inc   = 1'b1;
                    end
                end
            end
            ST_UPD: begin
                if (dp_done) begin
                    r_d.state = ST_SUM;
                    r_d.go    = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, go: 1'b0, fin: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    routing_iter_cnt #(.IW(IW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cnt_load),
        .lim_in (num_iters),
        .inc    (cnt_inc),
        .clear  (cnt_clear),
        .iter_o (iter_idx),
        .last_o (cnt_last)
    );

    routing_phase_decode u_dec (
        .state       (r_q.state),
        .dp_valid    (dp_valid),
        .data_sel    (data_sel),
        .coef_sel    (coef_sel),
        .act_sel     (act_sel),
        .rbuf_region (rbuf_region),
        .rbuf_we     (rbuf_we),
        .busy        (busy)
    );

    assign phase_go = r_q.go;
    assign done     = r_q.fin;
endmodule

// File: rtl/routing_seq_chk.sv
module routing_seq_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          dp_valid,
    input logic          dp_done,
    input logic          phase_go,
    input logic          data_sel,
    input logic          coef_sel,
    input logic [1:0]    act_sel,
    input logic          rbuf_we,
    input logic          rbuf_region,
    input logic          busy,
    input logic [IW-1:0] iter_idx,
    input logic          done
);
    // R2
    start_enters_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && phase_go && iter_idx == IW'(1)));

    // R3
    uniform_only_from_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_sel |-> (!data_sel && act_sel == 2'b01));

    // R5
    softmax_then_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel == 2'b10 && dp_done) |=> (act_sel == 2'b01 && data_sel && !rbuf_region && phase_go));

    // R7
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dp_done) |=> (busy && !phase_go && $stable(act_sel) && $stable(data_sel) && $stable(iter_idx)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && iter_idx == '0 && $past(dp_done)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!busy && !phase_go));

    // R11
    write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbuf_we |-> (busy && dp_valid));

    // R1
    act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (act_sel == 2'b00 && !rbuf_we));
endmodule

bind routing_seq_ctrl routing_seq_chk #(.IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .dp_valid(dp_valid), .dp_done(dp_done),
    .phase_go(phase_go), .data_sel(data_sel), .coef_sel(coef_sel), .act_sel(act_sel),
    .rbuf_we(rbuf_we), .rbuf_region(rbuf_region), .busy(busy), .iter_idx(iter_idx),
    .done(done)
);

// File: tb/routing_seq_ctrl_tb.sv
module routing_seq_ctrl_tb_top;
    localparam int  IW     = 4;
    localparam time CLK_P  = 10ns;
    localparam int  WD_MAX = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW-1:0] num_iters = '0;
    logic          dp_valid = 1'b0;
    logic          dp_done = 1'b0;
    logic          phase_go, data_sel, coef_sel, rbuf_we, rbuf_region, busy, done;
    logic [1:0]    act_sel;
    logic [IW-1:0] iter_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // reference model: queue of pending phases, entry = phase*16 + iteration
    int  q[$];
    bit  m_go = 1'b0;
    bit  m_done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    routing_seq_ctrl #(.IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .num_iters(num_iters),
        .dp_valid(dp_valid), .dp_done(dp_done), .phase_go(phase_go),
        .data_sel(data_sel), .coef_sel(coef_sel), .act_sel(act_sel),
        .rbuf_we(rbuf_we), .rbuf_region(rbuf_region), .busy(busy),
        .iter_idx(iter_idx), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete();
            m_go = 1'b0;
            m_done = 1'b0;
        end else begin
            m_go = 1'b0;
            m_done = 1'b0;
            if (q.size() == 0) begin
                if (start) begin
                    int n;
                    n = (num_iters == 0) ? 1 : int'(num_iters);
                    q.push_back(16 + 1);
                    for (int k = 2; k <= n; k++) begin
                        q.push_back(2*16 + k);
                        q.push_back(3*16 + k);
                    end
                    m_go = 1'b1;
                end
            end else if (dp_done) begin
                void'(q.pop_front());
                if (q.size() == 0) m_done = 1'b1;
                else m_go = 1'b1;
            end
        end
        #(CLK_P/4);
        if (rst_n) begin
            int ph, it, e_data, e_coef, e_act, e_reg;
            ph = (q.size() > 0) ? q[0] / 16 : 0;
            it = (q.size() > 0) ? q[0] % 16 : 0;
            e_data = (ph == 2 || ph == 3) ? 1 : 0;
            e_coef = (ph == 1) ? 1 : 0;
            e_act  = (ph == 2) ? 2 : (ph == 0 ? 0 : 1);
            e_reg  = (ph == 2) ? 1 : 0;
            chk("R2 R7 phase_go", int'(phase_go), int'(m_go));
            chk("R8 done", int'(done), int'(m_done));
            chk("R10 busy", int'(busy), (ph != 0) ? 1 : 0);
            chk("R6 iter_idx", int'(iter_idx), it);
            chk("R3 R4 R5 data_sel", int'(data_sel), e_data);
            chk("R3 coef_sel", int'(coef_sel), e_coef);
            chk("R4 R5 act_sel", int'(act_sel), e_act);
            chk("R4 rbuf_region", int'(rbuf_region), e_reg);
            chk("R11 rbuf_we", int'(rbuf_we), (ph != 0 && dp_valid) ? 1 : 0);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > WD_MAX) begin
            n_fail++;
            $display("FAIL watchdog at cycle %0d: actual hung expected finished", cyc);
            summary();
        end
    end

    task automatic kick(input int n);
        num_iters = IW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        num_iters = IW'(15);
    endtask

    task automatic phase(input int stall, input bit poke_start);
        while (!phase_go) @(negedge clk);
        for (int s = 0; s < stall; s++) begin
            dp_valid = (s % 2 == 0);
            start = poke_start && (s == 0);
            @(negedge clk);
        end
        start = 1'b0;
        dp_valid = 1'b1;
        dp_done = 1'b1;
        @(negedge clk);
        dp_done = 1'b0;
        dp_valid = 1'b0;
    endtask

    task automatic run(input int n, input int stall, input bit poke);
        int nn;
        nn = (n == 0) ? 1 : n;
        kick(n);
        for (int p = 0; p < 2*nn - 1; p++) phase(stall + (p % 3), poke);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state checked directly
        chk("R1 busy", int'(busy), 0);
        chk("R1 act_sel", int'(act_sel), 0);
        chk("R1 iter_idx", int'(iter_idx), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10: dp_done while idle ignored
        dp_done = 1'b1;
        @(negedge clk);
        dp_done = 1'b0;
        @(negedge clk);
        chk("R10 idle dp_done busy", int'(busy), 0);
        run(3, 2, 1'b0);   // R6 default count
        run(1, 1, 1'b0);   // R9 single
        run(0, 0, 1'b0);   // R9 zero treated as one
        run(5, 0, 1'b0);   // R7 zero stall
        run(4, 6, 1'b1);   // R10 start while busy, R7 long stall
        run(2, 3, 1'b0);
        summary();
    end
endmodule